// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It shifts a 16-bit segment base left by four bits and adds the offset. The block holds four segment bases: extra, code, stack and data. A load port writes any of them. Each request states what kind of access it is: an instruction fetch, a stack-pointer or frame-pointer based access, an access through any other base register, a string-move destination, or a far access that brings its own segment. The kind picks the segment unless the request carries an override.

The request side is a valid/ready stream. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. One cycle later its address sits in a single output register, flagged by `pa_valid`. The address is consumed on an edge where `pa_valid` and `pa_ready` are both high. `req_ready` is high when the output register is empty or is being drained in the same cycle. While the consumer holds `pa_ready` low and `pa_valid` is high, the output holds still and no new request is taken.

Top module: `seg_agu`

## Requirements
- R1: After reset `pa_valid` is 0. The code base is 0xFFFF and the stack, data and extra bases are 0x0000.
- R2: The address is base*16 + offset, kept to its low 20 bits. A sum at or above 2^20 wraps around.
- R3: Kind 0 (fetch) uses the code base. Segment select codes: 0 extra, 1 code, 2 stack, 3 data.
- R4: Kind 1 (SP/BP based) uses the stack base.
- R5: Kind 2 (other base register) uses the data base. Kinds 5 to 7 behave as kind 2.
- R6: Kind 3 (string destination) always uses the extra base. An override on this kind is ignored.
- R7: With `req_ovr_en` high, kinds 0, 1, 2 and 5 to 7 use the base named by `req_ovr_sel` in place of their default.
- R8: Kind 4 (far) uses `req_far_seg` as the base. Any override on this kind is ignored.
- R9: A load written with `seg_ld_en` takes effect on the next edge. A request accepted on the same edge as a load uses the base value from before that load.
- R10: An accepted request's address appears with `pa_valid` high in the next cycle.
- R11: While `pa_valid` is high and `pa_ready` is low, `pa_addr` stays unchanged and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_ld_en | input | 1 | Write a segment base |
| seg_ld_sel | input | 2 | Base to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_ld_val | input | 16 | Value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 3 | Access kind (0 fetch, 1 SP/BP, 2 other, 3 string dest, 4 far) |
| req_off | input | 16 | Offset |
| req_far_seg | input | 16 | Explicit base for kind 4 |
| req_ovr_en | input | 1 | Override the default base |
| req_ovr_sel | input | 2 | Base used when overriding |
| pa_valid | output | 1 | Output address present |
| pa_ready | input | 1 | Consumer takes the address |
| pa_addr | output | 20 | Physical address |

## Verification
On every cycle the assertions check four things: that a string destination selects the extra base, that the low nibble of the offset reaches the address unchanged, that a load lands in its register, and that the output handshake behaves as R10 and R11 state. Only the bench scenarios can show that each kind and override gives the full expected address. They also show the reset bases, wrap-around at 2^20, the old-value rule for a load and request on the same edge, and that results are neither lost nor duplicated while the consumer stalls.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int NUM_SEGS = 4;
  localparam int SEL_W    = $clog2(NUM_SEGS);

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_STACK  = 3'd1,
    KIND_DATA   = 3'd2,
    KIND_STRDST = 3'd3,
    KIND_FAR    = 3'd4
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_agu_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter logic [SEG_W-1:0] CS_RST = '1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_en,
  input  logic [SEL_W-1:0]               ld_sel,
  input  logic [SEG_W-1:0]               ld_val,
  output logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q
);
  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (i == int'(SEG_CS)) ? CS_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  seg_q[i] <= RST_VAL;
      else if (ld_en && (ld_sel == SEL_W'(i)))     seg_q[i] <= ld_val;
    end
  end

  // R9
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> seg_q[$past(ld_sel)] == $past(ld_val));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [2:0]                     kind,
  input  logic                           ovr_en,
  input  logic [SEL_W-1:0]               ovr_sel,
  input  logic [SEG_W-1:0]               far_seg,
  input  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q,
  output seg_id_e                        sel_id,
  output logic [SEG_W-1:0]               base
);
  seg_id_e dflt_id;

  always_comb begin
    case (kind)
      KIND_FETCH:  dflt_id = SEG_CS;
      KIND_STACK:  dflt_id = SEG_SS;
      KIND_STRDST: dflt_id = SEG_ES;
      default:     dflt_id = SEG_DS;
    endcase
    if (ovr_en && kind != KIND_STRDST && kind != KIND_FAR)
      sel_id = seg_id_e'(ovr_sel);
    else
      sel_id = dflt_id;
    base = (kind == KIND_FAR) ? far_seg : seg_q[sel_id];
  end
endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] base,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] base_sh;
  logic [PA_W-1:0] off_ext;

  assign base_sh = {base, {SHIFT{1'b0}}};
  assign off_ext = PA_W'(off);
  assign pa      = base_sh + off_ext;
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CS_RST = '1,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_ld_en,
  input  logic [1:0]       seg_ld_sel,
  input  logic [SEG_W-1:0] seg_ld_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [OFF_W-1:0] req_off,
  input  logic [SEG_W-1:0] req_far_seg,
  input  logic             req_ovr_en,
  input  logic [1:0]       req_ovr_sel,
  output logic             pa_valid,
  input  logic             pa_ready,
  output logic [PA_W-1:0]  pa_addr
);
  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
  seg_id_e                        sel_id;
  logic [SEG_W-1:0]               base;
  logic [PA_W-1:0]                pa_next;
  logic                           take;

  seg_regfile #(.SEG_W(SEG_W), .CS_RST(CS_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_en(seg_ld_en), .ld_sel(seg_ld_sel),
    .ld_val(seg_ld_val), .seg_q(seg_q)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .kind(req_kind), .ovr_en(req_ovr_en), .ovr_sel(req_ovr_sel),
    .far_seg(req_far_seg), .seg_q(seg_q), .sel_id(sel_id), .base(base)
  );

  seg_addr_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .base(base), .off(req_off), .pa(pa_next)
  );

  assign req_ready = !pa_valid || pa_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa_addr  <= '0;
    end else begin
      if (take) begin
        pa_valid <= 1'b1;
        pa_addr  <= pa_next;
      end else if (pa_ready) begin
        pa_valid <= 1'b0;
      end
    end
  end

  // R6
  strdst_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == KIND_STRDST) |-> sel_id == SEG_ES);

  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pa_addr[SHIFT-1:0] == $past(req_off[SHIFT-1:0]));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pa_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_ready) |=> (pa_valid && $stable(pa_addr)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_ready) |-> !req_ready);
endmodule

// File: tb/seg_agu_bench.sv
module seg_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_ld_en = 1'b0;
  logic [1:0]  seg_ld_sel = '0;
  logic [15:0] seg_ld_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_off = '0;
  logic [15:0] req_far_seg = '0;
  logic        req_ovr_en = 1'b0;
  logic [1:0]  req_ovr_sel = '0;
  logic        pa_valid;
  logic        pa_ready = 1'b1;
  logic [19:0] pa_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] model_seg [4];
  logic [19:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  seg_agu u_seg_agu (
    .clk(clk), .rst_n(rst_n), .seg_ld_en(seg_ld_en), .seg_ld_sel(seg_ld_sel),
    .seg_ld_val(seg_ld_val), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_off(req_off), .req_far_seg(req_far_seg),
    .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .pa_valid(pa_valid),
    .pa_ready(pa_ready), .pa_addr(pa_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_pa(input logic [2:0] kind, input logic [15:0] off,
                                            input logic [15:0] far, input logic oen,
                                            input logic [1:0] osel);
    logic [15:0] b;
    logic [1:0]  s;
    case (kind)
      3'd0:    s = 2'd1;
      3'd1:    s = 2'd2;
      3'd3:    s = 2'd0;
      default: s = 2'd3;
    endcase
    if (oen && kind != 3'd3 && kind != 3'd4) s = osel;
    b = (kind == 3'd4) ? far : model_seg[s];
    return 20'((32'(b) * 16 + 32'(off)) % 32'h100000);
  endfunction

  task automatic send(input string tag, input logic [2:0] kind, input logic [15:0] off,
                      input logic [15:0] far, input logic oen, input logic [1:0] osel);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = kind; req_off = off;
    req_far_seg = far; req_ovr_en = oen; req_ovr_sel = osel;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_q.push_back(expect_pa(kind, off, far, oen, osel));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0; req_ovr_en = 1'b0;
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] val);
    @(posedge clk); #1;
    seg_ld_en = 1'b1; seg_ld_sel = sel; seg_ld_val = val;
    @(posedge clk); #1;
    seg_ld_en = 1'b0;
    model_seg[sel] = val;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pa_valid && pa_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected output", 32'(pa_addr), 32'hFFFFFFFF);
        end else begin
          check(tag_q.pop_front(), 32'(pa_addr), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_seg[0] = 16'h0000; model_seg[1] = 16'hFFFF;
    model_seg[2] = 16'h0000; model_seg[3] = 16'h0000;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pa_valid after reset", 32'(pa_valid), 32'd0);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);

    send("R1 R3 fetch reset CS", 3'd0, 16'h0000, 16'h0, 1'b0, 2'd0);
    send("R1 R5 data reset DS", 3'd2, 16'h1234, 16'h0, 1'b0, 2'd0);
    send("R2 wrap past 1MiB", 3'd0, 16'h0010, 16'h0, 1'b0, 2'd0);

    load(2'd3, 16'h1000);
    load(2'd2, 16'h2000);
    load(2'd0, 16'h3000);
    load(2'd1, 16'h0800);

    send("R3 fetch CS", 3'd0, 16'h0100, 16'h0, 1'b0, 2'd0);
    send("R4 stack SS", 3'd1, 16'h0004, 16'h0, 1'b0, 2'd0);
    send("R5 data DS", 3'd2, 16'hABCD, 16'h0, 1'b0, 2'd0);
    send("R5 kind7 as data", 3'd7, 16'h0001, 16'h0, 1'b0, 2'd0);
    send("R6 strdst ES", 3'd3, 16'h0002, 16'h0, 1'b0, 2'd0);
    send("R6 strdst ignores override", 3'd3, 16'h0002, 16'h0, 1'b1, 2'd2);
    send("R7 data override ES", 3'd2, 16'h0005, 16'h0, 1'b1, 2'd0);
    send("R7 fetch override DS", 3'd0, 16'h0077, 16'h0, 1'b1, 2'd3);
    send("R7 stack override CS", 3'd1, 16'h0009, 16'h0, 1'b1, 2'd1);
    send("R8 far ignores override", 3'd4, 16'hFFFF, 16'hF000, 1'b1, 2'd2);
    send("R2 R8 far wrap", 3'd4, 16'hFFFF, 16'hFFFF, 1'b0, 2'd0);

    // R9: load and request on the same edge
    @(posedge clk); #1;
    seg_ld_en = 1'b1; seg_ld_sel = 2'd3; seg_ld_val = 16'h5000;
    req_valid = 1'b1; req_kind = 3'd2; req_off = 16'h0000; req_ovr_en = 1'b0;
    @(negedge clk);
    check("R9 req_ready during load", 32'(req_ready), 32'd1);
    exp_q.push_back(expect_pa(3'd2, 16'h0000, 16'h0, 1'b0, 2'd0));
    tag_q.push_back("R9 same-edge uses old DS");
    @(posedge clk); #1;
    seg_ld_en = 1'b0; req_valid = 1'b0;
    model_seg[3] = 16'h5000;
    send("R9 new DS after load", 3'd2, 16'h0000, 16'h0, 1'b0, 2'd0);

    // R10 R11: back-pressure
    @(posedge clk); #1;
    pa_ready = 1'b0;
    send("R11 first under stall", 3'd1, 16'h0030, 16'h0, 1'b0, 2'd0);
    fork
      send("R11 second after stall", 3'd0, 16'h0040, 16'h0, 1'b0, 2'd0);
      begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check("R10 R11 valid held", 32'(pa_valid), 32'd1);
          check("R11 ready low", 32'(req_ready), 32'd0);
          check("R11 address held", 32'(pa_addr), 32'h20030);
        end
        @(posedge clk); #1;
        pa_ready = 1'b1;
      end
    join

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
    check("R10 pa_valid idle", 32'(pa_valid), 32'd0);
    finish_run();
  end
endmodule